// File: doc/BRIEF.md
# Panel Self-Refresh State Controller

This block steers one display pipe through the self-refresh states of an embedded panel that keeps its own copy of the frame. Software owns some transitions: it turns the feature on, asks for entry, asks for exit, turns the feature off and requests a single-frame update before a flip. The block owns the others: it waits for enough unchanged frames before the panel is put to sleep, folds a pending single-frame update into one refreshed frame, and completes an exit once the sink has been woken.

On every exit the block raises a one-cycle request to the sideband channel to write the wake-up power value to the sink. It then holds the exit state until that channel acknowledges the write. A frame-count bound on sleep forces the same exit path without software. A disable request that arrives while a transition is under way is held back until the transition ends.

Top module: `selfrefresh_ctrl`

## Requirements
- R1: After synchronous active-low reset, state_code is 0 and in_transition, active, sfu_pending and wake_pulse are all low. The state_code values are 0 off, 1 armed, 2 entering (static frame sent), 3 asleep with no panel-buffer update, 4 sending one refreshed frame, 5 leaving.
- R2: enable_req moves state 0 to state 1 on the next clock. activate_req in state 0 and enable_req in any other state have no effect.
- R3: activate_req moves state 1 to state 2. in_transition is high exactly in states 2 and 5. active is high exactly in states 3 and 4.
- R4: State 2 moves to state 3 on the frame_tick that completes T consecutive ticks without frame_dirty, where T is the larger of idle_cfg and 6. Any frame_dirty restarts the count from zero.
- R5: exit_req in state 3 or 4 moves the block to state 5, never through state 4. wake_pulse is high for exactly the first cycle of state 5.
- R6: State 5 is held until wake_ack, then the block returns to state 1.
- R7: sfu_req sets sfu_pending in any state except 0. In state 3 with sfu_pending set, a frame_tick moves to state 4. The next frame_tick returns to state 3. Each entry into state 3 clears sfu_pending.
- R8: After SLEEP_FRAMES frame_ticks in state 3, the block leaves for state 5 on its own and raises wake_pulse.
- R9: disable_req moves states 1, 3 and 4 to state 0 on the next clock. In states 2 and 5 the request is remembered and takes effect one cycle after the block leaves the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_req | input | 1 | Turn the feature on (state 0 to 1) |
| disable_req | input | 1 | Turn the feature off |
| activate_req | input | 1 | Begin entry (state 1 to 2) |
| exit_req | input | 1 | Leave self-refresh |
| sfu_req | input | 1 | Request a single refreshed frame |
| frame_tick | input | 1 | One-cycle vertical-blank strobe |
| frame_dirty | input | 1 | Frame content changed |
| idle_cfg | input | IDLE_W | Programmed idle-frame count (floored at 6) |
| wake_ack | input | 1 | Sideband wake-up write issued |
| state_code | output | 3 | Current state code |
| in_transition | output | 1 | High in states 2 and 5 |
| active | output | 1 | High in states 3 and 4 |
| sfu_pending | output | 1 | Single-frame-update request bit |
| wake_pulse | output | 1 | One-cycle wake-up write request |

## Verification
The bench builds the block with IDLE_W = 4 and SLEEP_FRAMES = 10. A short sleep bound lets the forced exit be reached in a few frames. The 4-bit idle field lets idle_cfg be set both below the floor (3, which behaves as 6) and above it (9). Deferred disables are driven in both transition states, single-frame updates are driven both before and during sleep, and exits are taken from both sleeping states.

// File: rtl/srf_pkg.sv
// Shared types for the self-refresh controller.
package srf_pkg;
    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_ARMED  = 3'd1,
        ST_ENTER  = 3'd2,
        ST_SLEEP  = 3'd3,
        ST_SINGLE = 3'd4,
        ST_LEAVE  = 3'd5
    } srf_state_e;

    localparam int IDLE_FLOOR = 6;
endpackage

// File: rtl/srf_frame_cnt.sv
// Frame counter: counts tick strobes until limit is reached.
// Assumes limit >= 1. hit is combinational and high on the tick that
// completes limit consecutive counts. clr wins over tick.
module srf_frame_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    // Count ticks, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end

    // Completion when this tick is the limit-th one.
    assign hit = tick && !clr && (cnt == limit - 1'b1);

    a_r4_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/srf_fsm.sv
// Self-refresh state machine. Owns the six-state sequence, the
// single-frame-update bit, deferred disable and the wake-up pulse.
// Assumes idle_hit and sleep_hit come from frame counters that are
// held clear outside states 2 and 3 respectively.
module srf_fsm
    import srf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_req,
    input  logic       disable_req,
    input  logic       activate_req,
    input  logic       exit_req,
    input  logic       sfu_req,
    input  logic       frame_tick,
    input  logic       idle_hit,
    input  logic       sleep_hit,
    input  logic       wake_ack,
    output srf_state_e state,
    output logic       sfu_pending,
    output logic       wake_pulse
);
    srf_state_e state_n;
    logic       dis_pend;
    logic       busy;
    logic       dis_go;

    assign busy   = (state == ST_ENTER) || (state == ST_LEAVE);
    assign dis_go = (disable_req || dis_pend) && !busy && (state != ST_OFF);

    // Next-state selection; disable takes priority where allowed.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_OFF:    if (enable_req) state_n = ST_ARMED;
            ST_ARMED:  if (dis_go) state_n = ST_OFF;
                       else if (activate_req) state_n = ST_ENTER;
            ST_ENTER:  if (idle_hit) state_n = ST_SLEEP;
            ST_SLEEP:  if (dis_go) state_n = ST_OFF;
                       else if (exit_req || sleep_hit) state_n = ST_LEAVE;
                       else if (sfu_pending && frame_tick) state_n = ST_SINGLE;
            ST_SINGLE: if (dis_go) state_n = ST_OFF;
                       else if (exit_req) state_n = ST_LEAVE;
                       else if (frame_tick) state_n = ST_SLEEP;
            ST_LEAVE:  if (wake_ack) state_n = ST_ARMED;
            default:   state_n = ST_OFF;
        endcase
    end

    // State register and wake pulse on entry to the leaving state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            wake_pulse <= 1'b0;
        end else begin
            state      <= state_n;
            wake_pulse <= (state_n == ST_LEAVE) && (state != ST_LEAVE);
        end
    end

    // Remember a disable that arrived during a transition.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_OFF || dis_go) dis_pend <= 1'b0;
        else if (disable_req)                    dis_pend <= 1'b1;
    end

    // Single-frame-update bit: set by request, clears on entry to sleep.
    always_ff @(posedge clk) begin
        if (!rst_n || state_n == ST_OFF)                 sfu_pending <= 1'b0;
        else if (sfu_req && state != ST_OFF)             sfu_pending <= 1'b1;
        else if (state_n == ST_SLEEP && state != ST_SLEEP) sfu_pending <= 1'b0;
    end

    a_r2_enable_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && enable_req) |=> (state == ST_ARMED));
    a_r2_off_only_to_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> (state == ST_OFF || state == ST_ARMED));
    a_r5_exit_skips_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && exit_req && !disable_req && !dis_pend)
        |=> (state == ST_LEAVE && wake_pulse));
    a_r5_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
    a_r6_hold_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAVE && !wake_ack) |=> (state == ST_LEAVE));
    a_r9_no_off_from_transition: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state != ST_OFF));
    a_r7_sfu_clears_on_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sfu_pending) |-> (state == ST_SLEEP || state == ST_OFF));
endmodule

// File: rtl/selfrefresh_ctrl.sv
// Panel self-refresh controller top. Floors the programmed idle count,
// runs the idle-frame and sleep-bound counters and the state machine.
// Assumes frame_tick is a one-cycle strobe and IDLE_W >= 3.
module selfrefresh_ctrl
    import srf_pkg::*;
#(
    parameter int          IDLE_W       = 4,
    parameter int          SLEEP_W      = 5,
    parameter logic [4:0]  SLEEP_FRAMES = 5'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_req,
    input  logic              disable_req,
    input  logic              activate_req,
    input  logic              exit_req,
    input  logic              sfu_req,
    input  logic              frame_tick,
    input  logic              frame_dirty,
    input  logic [IDLE_W-1:0] idle_cfg,
    input  logic              wake_ack,
    output logic [2:0]        state_code,
    output logic              in_transition,
    output logic              active,
    output logic              sfu_pending,
    output logic              wake_pulse
);
    localparam logic [IDLE_W-1:0]  FLOOR_V = IDLE_W'(IDLE_FLOOR);
    localparam logic [SLEEP_W-1:0] SLEEP_V = SLEEP_W'(SLEEP_FRAMES);

    srf_state_e        state;
    logic [IDLE_W-1:0] idle_thr;
    logic              idle_hit;
    logic              sleep_hit;

    // Idle threshold is never below the floor.
    assign idle_thr = (idle_cfg < FLOOR_V) ? FLOOR_V : idle_cfg;

    srf_frame_cnt #(.W(IDLE_W)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state != ST_ENTER) || frame_dirty),
        .tick  (frame_tick),
        .limit (idle_thr),
        .hit   (idle_hit)
    );

    srf_frame_cnt #(.W(SLEEP_W)) u_sleep (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_SLEEP),
        .tick  (frame_tick),
        .limit (SLEEP_V),
        .hit   (sleep_hit)
    );

    srf_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_req   (enable_req),
        .disable_req  (disable_req),
        .activate_req (activate_req),
        .exit_req     (exit_req),
        .sfu_req      (sfu_req),
        .frame_tick   (frame_tick),
        .idle_hit     (idle_hit),
        .sleep_hit    (sleep_hit),
        .wake_ack     (wake_ack),
        .state        (state),
        .sfu_pending  (sfu_pending),
        .wake_pulse   (wake_pulse)
    );

    assign state_code    = state;
    assign in_transition = (state == ST_ENTER) || (state == ST_LEAVE);
    assign active        = (state == ST_SLEEP) || (state == ST_SINGLE);

    a_r3_active_not_transition: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && in_transition));
    a_r4_enter_needs_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER && idle_hit) |-> (idle_thr >= FLOOR_V));
    a_r8_sleep_exit_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && sleep_hit && !disable_req) |=> wake_pulse);
endmodule

// File: tb/sim_selfrefresh_ctrl.sv
module sim_selfrefresh_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE_W     = 4;
    localparam int SLEEP_N    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_req = 0, disable_req = 0, activate_req = 0, exit_req = 0;
    logic sfu_req = 0, frame_tick = 0, frame_dirty = 0, wake_ack = 0;
    logic [IDLE_W-1:0] idle_cfg = 4'd3;
    logic [2:0] state_code;
    logic in_transition, active, sfu_pending, wake_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    selfrefresh_ctrl #(.IDLE_W(IDLE_W), .SLEEP_W(5), .SLEEP_FRAMES(5'd10)) u0 (
        .clk(clk), .rst_n(rst_n), .enable_req(enable_req), .disable_req(disable_req),
        .activate_req(activate_req), .exit_req(exit_req), .sfu_req(sfu_req),
        .frame_tick(frame_tick), .frame_dirty(frame_dirty), .idle_cfg(idle_cfg),
        .wake_ack(wake_ack), .state_code(state_code), .in_transition(in_transition),
        .active(active), .sfu_pending(sfu_pending), .wake_pulse(wake_pulse)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic do_reset();
        rst_n = 0; step(); step(); rst_n = 1; step();
    endtask

    task automatic p_enable();   enable_req = 1;   step(); enable_req = 0;   endtask
    task automatic p_disable();  disable_req = 1;  step(); disable_req = 0;  endtask
    task automatic p_activate(); activate_req = 1; step(); activate_req = 0; endtask
    task automatic p_exit();     exit_req = 1;     step(); exit_req = 0;     endtask
    task automatic p_sfu();      sfu_req = 1;      step(); sfu_req = 0;      endtask
    task automatic p_ack();      wake_ack = 1;     step(); wake_ack = 0;     endtask

    task automatic frames(input int n, input bit dirty);
        for (int i = 0; i < n; i++) begin
            frame_tick = 1; frame_dirty = dirty; step();
            frame_tick = 0; frame_dirty = 0;
        end
    endtask

    task automatic go_sleep();
        do_reset(); idle_cfg = 4'd3; p_enable(); p_activate(); frames(6, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 state", state_code, 0);
        chk("R1 outputs", {in_transition, active, sfu_pending, wake_pulse}, 0);
    endtask

    task automatic t_arm();
        do_reset();
        p_activate(); chk("R2 activate ignored in off", state_code, 0);
        p_enable();   chk("R2 enable arms", state_code, 1);
        p_enable();   chk("R2 enable ignored when armed", state_code, 1);
        chk("R3 no transition in armed", in_transition, 0);
        p_activate(); chk("R3 activate enters", state_code, 2);
        chk("R3 in_transition in entering", in_transition, 1);
        chk("R3 not active in entering", active, 0);
    endtask

    task automatic t_idle();
        do_reset(); idle_cfg = 4'd3; p_enable(); p_activate();
        frames(5, 0); chk("R4 below floor waits", state_code, 2);
        frames(1, 1); frames(5, 0); chk("R4 dirty restarts", state_code, 2);
        frames(1, 0); chk("R4 floor reached", state_code, 3);
        chk("R3 active in sleep", active, 1);
        chk("R3 no transition in sleep", in_transition, 0);
        do_reset(); idle_cfg = 4'd9; p_enable(); p_activate();
        frames(8, 0); chk("R4 above floor waits", state_code, 2);
        frames(1, 0); chk("R4 programmed count reached", state_code, 3);
    endtask

    task automatic t_exit();
        go_sleep();
        p_exit();
        chk("R5 exit to leaving", state_code, 5);
        chk("R5 wake pulse", wake_pulse, 1);
        chk("R3 in_transition in leaving", in_transition, 1);
        step(); chk("R5 wake pulse one cycle", wake_pulse, 0);
        step(); step(); chk("R6 holds until ack", state_code, 5);
        p_ack(); chk("R6 ack returns to armed", state_code, 1);
    endtask

    task automatic t_sfu();
        do_reset();
        p_sfu(); chk("R7 sfu ignored in off", sfu_pending, 0);
        idle_cfg = 4'd3; p_enable();
        p_sfu(); chk("R7 sfu set when armed", sfu_pending, 1);
        p_activate(); frames(6, 0);
        chk("R7 entry reaches sleep", state_code, 3);
        chk("R7 cleared on entry", sfu_pending, 0);
        p_sfu(); chk("R7 sfu set in sleep", sfu_pending, 1);
        frames(1, 0); chk("R7 single update state", state_code, 4);
        frames(1, 0); chk("R7 back to sleep", state_code, 3);
        chk("R7 self-cleared", sfu_pending, 0);
        p_sfu(); frames(1, 0); chk("R7 single update again", state_code, 4);
        p_exit(); chk("R5 exit from single update", state_code, 5);
        chk("R5 wake from single update", wake_pulse, 1);
    endtask

    task automatic t_sleep();
        go_sleep();
        frames(SLEEP_N - 1, 0); chk("R8 before bound", state_code, 3);
        frames(1, 0);
        chk("R8 bound forces leave", state_code, 5);
        chk("R8 bound raises wake", wake_pulse, 1);
    endtask

    task automatic t_disable();
        go_sleep();
        p_disable(); chk("R9 disable from sleep", state_code, 0);
        do_reset(); idle_cfg = 4'd3; p_enable(); p_activate();
        p_disable(); chk("R9 deferred in entering", state_code, 2);
        frames(6, 0); chk("R9 entry completes first", state_code, 3);
        step(); chk("R9 deferred disable applied", state_code, 0);
        go_sleep(); p_exit();
        p_disable(); chk("R9 deferred in leaving", state_code, 5);
        p_ack(); chk("R9 leave completes first", state_code, 1);
        step(); chk("R9 deferred disable after leave", state_code, 0);
    endtask

    initial begin
        t_reset();
        t_arm();
        t_idle();
        t_exit();
        t_sfu();
        t_sleep();
        t_disable();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule